// File: doc/BRIEF.md
# Interrupt Controller Register Decoder

This block is the 32-bit memory-mapped front end of a wired-interrupt controller that forwards its sources as messages. A requester issues one access per cycle on a simple request/response bus. The block decodes the word offset into a register group. It returns read data one cycle later, together with an error flag. Writes are turned into one-cycle command pulses toward the per-source state logic: set or clear masks for the pending and enable bits, configuration and target array writes, and a message-generation strobe. The block itself holds only the domain enable bit and the last message word. Everything else it reads from the source logic's state vectors.

Sources are numbered 1 to `NSRC`; source 0 does not exist. Bit-vector arrays cover `NW = ceil((NSRC+1)/32)` words, and bit `i` of word `w` stands for source `32*w+i`. Bus handling is a three-state machine. `ST_IDLE` means no response is due. `ST_ACK` means an accepted access is answered without error. `ST_NAK` means a rejected access is answered with the error flag. Every cycle the next state is picked from that cycle's request alone. The transitions are: no request to `ST_IDLE`, a good request to `ST_ACK`, and a bad request to `ST_NAK`. The transitions are the same from every state, so back-to-back accesses are answered on consecutive cycles.

Top module: `intc_reg_decoder`

## Requirements
- R1: An access is rejected when the offset is not a multiple of 4, when `req_size` (a byte count) is not 4, or when the offset matches no register. A rejected access is answered with `rsp_err`=1 and `rsp_rdata`=0, and it produces no command pulse and no state change.
- R2: Every request cycle is followed by exactly one cycle with `rsp_valid`=1. A cycle without a request is followed by `rsp_valid`=0. After reset, `rsp_valid` is 0.
- R3: The domain register at offset 0x0000 reads as 0x8000_0004 with bit 8 replaced by the stored enable bit. A write keeps only bit 8 of the data in that bit, which drives `dom_ie`. The enable bit resets to 0 and changes only on a domain write.
- R4: The configuration array occupies offsets 0x0004 + 4k for k = 0..NSRC-1, and word k belongs to source k+1. A read returns `src_cfg[k]`. A write pulses `cfg_we` for one cycle with `arr_idx`=k+1 and `arr_wdata` set to the raw data.
- R5: The target array occupies offsets 0x3004 + 4k for k = 0..NSRC-1, and word k belongs to source k+1. A read returns `src_tgt[k]`. A write pulses `tgt_we` with `arr_idx`=k+1 and the raw data.
- R6: Word w of the bit-vector arrays reads as follows: at 0x1C00+4w, the pending bits; at 0x1D00+4w, the input levels; at 0x1E00+4w, the enable bits; at 0x1F00+4w, zero. In each word, bit i is source 32w+i, and bits for source 0 or for sources above NSRC read 0.
- R7: A write to word w of those arrays (0x1C00 pending-set, 0x1D00 pending-clear, 0x1E00 enable-set, 0x1F00 enable-clear) raises, for one cycle, the bit of each source 32w+i whose data bit i is 1 in `pend_set`, `pend_clr`, `en_set` or `en_clr` respectively. Sources whose data bit is 0 are left untouched.
- R8: The by-number registers are pending-set 0x1CDC, pending-clear 0x1DDC, enable-set 0x1EDC, enable-clear 0x1FDC and little-endian pending-set 0x2000. They read as 0. A write of value v with 1 <= v <= NSRC raises only bit v of the matching mask for one cycle. Any other value raises nothing.
- R9: The big-endian pending-set register at 0x2004 reads as 0. A write reverses the byte order of the data and then acts as a pending-set by number.
- R10: The message register at 0x3000 reads back the last written value with bits 17:12 cleared. Each write to it pulses `msg_fire` for one cycle, and `msg_word` carries the stored value.
- R11: Every output is 0 during and after reset until the first access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Byte offset inside the register window |
| req_size | input | 3 | Access size in bytes |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_err | output | 1 | Previous request was rejected |
| rsp_rdata | output | 32 | Read data (0 for writes and errors) |
| src_pend | input | NSRC | Pending bits of sources NSRC..1 |
| src_en | input | NSRC | Enable bits of sources NSRC..1 |
| src_lvl | input | NSRC | Latched input levels of sources NSRC..1 |
| src_cfg | input | NSRC x 32 | Configuration word of source k+1 at index k |
| src_tgt | input | NSRC x 32 | Target word of source k+1 at index k |
| pend_set | output | NSRC | One-cycle pending-set mask |
| pend_clr | output | NSRC | One-cycle pending-clear mask |
| en_set | output | NSRC | One-cycle enable-set mask |
| en_clr | output | NSRC | One-cycle enable-clear mask |
| cfg_we | output | 1 | Configuration array write strobe |
| tgt_we | output | 1 | Target array write strobe |
| arr_idx | output | IDXW | Source number for array writes |
| arr_wdata | output | 32 | Data for array writes |
| msg_fire | output | 1 | Message-generation strobe |
| msg_word | output | 32 | Stored message word |
| dom_ie | output | 1 | Domain enable bit |

## Verification
The stimulus draws offsets from every register group, with array indices that run one word past the end of each group, mixed with misaligned offsets, wrong sizes and arbitrary offsets. This separates range decoding from alignment and size rejection. By-number writes use values from 0 to a few above NSRC, and the big-endian register receives byte-swapped forms of those values. A wrong endianness, an off-by-one bound or a source-0 leak therefore each produces a wrong mask bit. The state vectors are redrawn before every access, so a read mux that selects the wrong vector or the wrong word shows up as a data mismatch. Directed cases cover the last configuration word, the first word past it, bit 0 of vector word 0, the top source bit, and all-ones writes to the domain and message registers.

// File: rtl/ird_pkg.sv
`timescale 1ns/1ps
package ird_pkg;

    typedef enum logic [3:0] {
        RG_NONE,
        RG_DOMAIN,
        RG_CFG,
        RG_TGT,
        RG_PSET_VEC,
        RG_PCLR_VEC,
        RG_ESET_VEC,
        RG_ECLR_VEC,
        RG_PSET_NUM,
        RG_PCLR_NUM,
        RG_ESET_NUM,
        RG_ECLR_NUM,
        RG_PSET_LE,
        RG_PSET_BE,
        RG_MSG
    } region_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ACK,
        ST_NAK
    } bus_state_e;

    localparam logic [31:0] OFF_DOMAIN   = 32'h0000_0000;
    localparam logic [31:0] OFF_CFG      = 32'h0000_0004;
    localparam logic [31:0] OFF_PSET_VEC = 32'h0000_1C00;
    localparam logic [31:0] OFF_PSET_NUM = 32'h0000_1CDC;
    localparam logic [31:0] OFF_PCLR_VEC = 32'h0000_1D00;
    localparam logic [31:0] OFF_PCLR_NUM = 32'h0000_1DDC;
    localparam logic [31:0] OFF_ESET_VEC = 32'h0000_1E00;
    localparam logic [31:0] OFF_ESET_NUM = 32'h0000_1EDC;
    localparam logic [31:0] OFF_ECLR_VEC = 32'h0000_1F00;
    localparam logic [31:0] OFF_ECLR_NUM = 32'h0000_1FDC;
    localparam logic [31:0] OFF_PSET_LE  = 32'h0000_2000;
    localparam logic [31:0] OFF_PSET_BE  = 32'h0000_2004;
    localparam logic [31:0] OFF_MSG      = 32'h0000_3000;
    localparam logic [31:0] OFF_TGT      = 32'h0000_3004;

    localparam logic [31:0] DOM_FIXED    = 32'h8000_0004;
    localparam int          DOM_IE_BIT   = 8;
    localparam logic [31:0] MSG_CLR_MASK = 32'h0003_F000;
    localparam logic [2:0]  WORD_BYTES   = 3'd4;

endpackage

// File: rtl/ird_decode.sv
`timescale 1ns/1ps
module ird_decode
    import ird_pkg::*;
#(
    parameter int NSRC = 63,
    parameter int AW   = 15,
    parameter int IDXW = 6
) (
    input  logic [AW-1:0]   addr,
    input  logic [2:0]      size,
    output region_e         region,
    output logic [IDXW-1:0] index,
    output logic            err
);
    localparam int NW = (NSRC + 1 + 31) / 32;
    localparam logic [31:0] ARR_BYTES = 32'(NSRC * 4);
    localparam logic [31:0] VEC_BYTES = 32'(NW * 4);

    logic [31:0] off;
    logic [31:0] rel;

    assign off = 32'(addr);

    always_comb begin
        region = RG_NONE;
        rel    = '0;
        index  = '0;
        if (off == OFF_DOMAIN) begin
            region = RG_DOMAIN;
        end else if (off >= OFF_CFG && off < OFF_CFG + ARR_BYTES) begin
            region = RG_CFG;
            rel    = (off - OFF_CFG) >> 2;
            index  = IDXW'(rel) + IDXW'(1);
        end else if (off >= OFF_TGT && off < OFF_TGT + ARR_BYTES) begin
            region = RG_TGT;
            rel    = (off - OFF_TGT) >> 2;
            index  = IDXW'(rel) + IDXW'(1);
        end else if (off >= OFF_PSET_VEC && off < OFF_PSET_VEC + VEC_BYTES) begin
            region = RG_PSET_VEC;
            rel    = (off - OFF_PSET_VEC) >> 2;
            index  = IDXW'(rel);
        end else if (off >= OFF_PCLR_VEC && off < OFF_PCLR_VEC + VEC_BYTES) begin
            region = RG_PCLR_VEC;
            rel    = (off - OFF_PCLR_VEC) >> 2;
            index  = IDXW'(rel);
        end else if (off >= OFF_ESET_VEC && off < OFF_ESET_VEC + VEC_BYTES) begin
            region = RG_ESET_VEC;
            rel    = (off - OFF_ESET_VEC) >> 2;
            index  = IDXW'(rel);
        end else if (off >= OFF_ECLR_VEC && off < OFF_ECLR_VEC + VEC_BYTES) begin
            region = RG_ECLR_VEC;
            rel    = (off - OFF_ECLR_VEC) >> 2;
            index  = IDXW'(rel);
        end else if (off == OFF_PSET_NUM) begin
            region = RG_PSET_NUM;
        end else if (off == OFF_PCLR_NUM) begin
            region = RG_PCLR_NUM;
        end else if (off == OFF_ESET_NUM) begin
            region = RG_ESET_NUM;
        end else if (off == OFF_ECLR_NUM) begin
            region = RG_ECLR_NUM;
        end else if (off == OFF_PSET_LE) begin
            region = RG_PSET_LE;
        end else if (off == OFF_PSET_BE) begin
            region = RG_PSET_BE;
        end else if (off == OFF_MSG) begin
            region = RG_MSG;
        end
    end

    assign err = (addr[1:0] != 2'b00) || (size != WORD_BYTES) || (region == RG_NONE);

endmodule

// File: rtl/ird_rdmux.sv
`timescale 1ns/1ps
module ird_rdmux
    import ird_pkg::*;
#(
    parameter int NSRC = 63,
    parameter int IDXW = 6
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       rd_go,
    input  region_e                    region,
    input  logic [IDXW-1:0]            index,
    input  logic [NSRC:1]              src_pend,
    input  logic [NSRC:1]              src_en,
    input  logic [NSRC:1]              src_lvl,
    input  logic [NSRC-1:0][31:0]      src_cfg,
    input  logic [NSRC-1:0][31:0]      src_tgt,
    input  logic                       dom_ie,
    input  logic [31:0]                msg_word,
    output logic [31:0]                rdata
);
    localparam int NW   = (NSRC + 1 + 31) / 32;
    localparam int PADW = NW * 32;

    logic [PADW-1:0] pad_pend;
    logic [PADW-1:0] pad_en;
    logic [PADW-1:0] pad_lvl;
    logic [IDXW-1:0] arr_sel;
    logic [31:0]     sel_data;
    logic [31:0]     dom_word;

    assign pad_pend[0]      = 1'b0;
    assign pad_en[0]        = 1'b0;
    assign pad_lvl[0]       = 1'b0;
    assign pad_pend[NSRC:1] = src_pend;
    assign pad_en[NSRC:1]   = src_en;
    assign pad_lvl[NSRC:1]  = src_lvl;

    generate
        if (PADW - 1 > NSRC) begin : g_pad_hi
            assign pad_pend[PADW-1:NSRC+1] = '0;
            assign pad_en[PADW-1:NSRC+1]   = '0;
            assign pad_lvl[PADW-1:NSRC+1]  = '0;
        end
    endgenerate

    assign arr_sel  = index - IDXW'(1);
    assign dom_word = DOM_FIXED | (32'(dom_ie) << DOM_IE_BIT);

    always_comb begin
        unique case (region)
            RG_DOMAIN:   sel_data = dom_word;
            RG_CFG:      sel_data = src_cfg[arr_sel];
            RG_TGT:      sel_data = src_tgt[arr_sel];
            RG_PSET_VEC: sel_data = pad_pend[{index, 5'b0} +: 32];
            RG_PCLR_VEC: sel_data = pad_lvl[{index, 5'b0} +: 32];
            RG_ESET_VEC: sel_data = pad_en[{index, 5'b0} +: 32];
            RG_MSG:      sel_data = msg_word;
            default:     sel_data = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_go) begin
            rdata <= sel_data;
        end else begin
            rdata <= '0;
        end
    end

endmodule

// File: rtl/ird_wrfwd.sv
`timescale 1ns/1ps
module ird_wrfwd
    import ird_pkg::*;
#(
    parameter int NSRC = 63,
    parameter int IDXW = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_go,
    input  region_e           region,
    input  logic [IDXW-1:0]   index,
    input  logic [31:0]       wdata,
    output logic [NSRC:1]     pend_set,
    output logic [NSRC:1]     pend_clr,
    output logic [NSRC:1]     en_set,
    output logic [NSRC:1]     en_clr,
    output logic              cfg_we,
    output logic              tgt_we,
    output logic [IDXW-1:0]   arr_idx,
    output logic [31:0]       arr_wdata,
    output logic              msg_fire,
    output logic [31:0]       msg_word,
    output logic              dom_ie
);
    logic [31:0]   num_val;
    logic [NSRC:1] vec_hit;
    logic [NSRC:1] num_hit;

    assign num_val = (region == RG_PSET_BE)
                   ? {wdata[7:0], wdata[15:8], wdata[23:16], wdata[31:24]}
                   : wdata;

    generate
        for (genvar s = 1; s <= NSRC; s++) begin : g_src
            localparam int WORD = s / 32;
            localparam int BIT  = s % 32;
            assign vec_hit[s] = (index == IDXW'(WORD)) && wdata[BIT];
            assign num_hit[s] = (num_val == 32'(s));
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_set  <= '0;
            pend_clr  <= '0;
            en_set    <= '0;
            en_clr    <= '0;
            cfg_we    <= 1'b0;
            tgt_we    <= 1'b0;
            arr_idx   <= '0;
            arr_wdata <= '0;
            msg_fire  <= 1'b0;
            msg_word  <= '0;
            dom_ie    <= 1'b0;
        end else begin
            pend_set <= '0;
            pend_clr <= '0;
            en_set   <= '0;
            en_clr   <= '0;
            cfg_we   <= 1'b0;
            tgt_we   <= 1'b0;
            msg_fire <= 1'b0;
            if (wr_go) begin
                unique case (region)
                    RG_DOMAIN:   dom_ie   <= wdata[DOM_IE_BIT];
                    RG_CFG: begin
                        cfg_we    <= 1'b1;
                        arr_idx   <= index;
                        arr_wdata <= wdata;
                    end
                    RG_TGT: begin
                        tgt_we    <= 1'b1;
                        arr_idx   <= index;
                        arr_wdata <= wdata;
                    end
                    RG_PSET_VEC: pend_set <= vec_hit;
                    RG_PCLR_VEC: pend_clr <= vec_hit;
                    RG_ESET_VEC: en_set   <= vec_hit;
                    RG_ECLR_VEC: en_clr   <= vec_hit;
                    RG_PSET_NUM: pend_set <= num_hit;
                    RG_PSET_LE:  pend_set <= num_hit;
                    RG_PSET_BE:  pend_set <= num_hit;
                    RG_PCLR_NUM: pend_clr <= num_hit;
                    RG_ESET_NUM: en_set   <= num_hit;
                    RG_ECLR_NUM: en_clr   <= num_hit;
                    RG_MSG: begin
                        msg_fire <= 1'b1;
                        msg_word <= wdata & ~MSG_CLR_MASK;
                    end
                    default: ;
                endcase
            end
        end
    end

    AST_SET_CLR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(((|pend_set) && (|pend_clr)) || ((|en_set) && (|en_clr)))); // R7

    AST_IE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_go && region == RG_DOMAIN) |-> $stable(dom_ie)); // R3

    AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we || tgt_we) |-> (arr_idx != '0 && 32'(arr_idx) <= 32'(NSRC))); // R4

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({cfg_we, tgt_we, msg_fire}) <= 1); // R10

endmodule

// File: rtl/intc_reg_decoder.sv
`timescale 1ns/1ps
module intc_reg_decoder
    import ird_pkg::*;
#(
    parameter int NSRC = 63,
    parameter int AW   = 15,
    localparam int IDXW = $clog2(NSRC + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic                  req_write,
    input  logic [AW-1:0]         req_addr,
    input  logic [2:0]            req_size,
    input  logic [31:0]           req_wdata,
    output logic                  rsp_valid,
    output logic                  rsp_err,
    output logic [31:0]           rsp_rdata,
    input  logic [NSRC:1]         src_pend,
    input  logic [NSRC:1]         src_en,
    input  logic [NSRC:1]         src_lvl,
    input  logic [NSRC-1:0][31:0] src_cfg,
    input  logic [NSRC-1:0][31:0] src_tgt,
    output logic [NSRC:1]         pend_set,
    output logic [NSRC:1]         pend_clr,
    output logic [NSRC:1]         en_set,
    output logic [NSRC:1]         en_clr,
    output logic                  cfg_we,
    output logic                  tgt_we,
    output logic [IDXW-1:0]       arr_idx,
    output logic [31:0]           arr_wdata,
    output logic                  msg_fire,
    output logic [31:0]           msg_word,
    output logic                  dom_ie
);
    region_e         region;
    logic [IDXW-1:0] index;
    logic            dec_err;
    logic            rd_go;
    logic            wr_go;
    bus_state_e      state_q;
    bus_state_e      state_d;

    ird_decode #(.NSRC(NSRC), .AW(AW), .IDXW(IDXW)) u_decode (
        .addr   (req_addr),
        .size   (req_size),
        .region (region),
        .index  (index),
        .err    (dec_err)
    );

    assign rd_go = req_valid && !req_write && !dec_err;
    assign wr_go = req_valid &&  req_write && !dec_err;

    always_comb begin
        if (!req_valid)   state_d = ST_IDLE;
        else if (dec_err) state_d = ST_NAK;
        else              state_d = ST_ACK;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE: begin rsp_valid = 1'b0; rsp_err = 1'b0; end
            ST_ACK:  begin rsp_valid = 1'b1; rsp_err = 1'b0; end
            ST_NAK:  begin rsp_valid = 1'b1; rsp_err = 1'b1; end
            default: begin rsp_valid = 1'b0; rsp_err = 1'b0; end
        endcase
    end

    ird_rdmux #(.NSRC(NSRC), .IDXW(IDXW)) u_rdmux (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_go    (rd_go),
        .region   (region),
        .index    (index),
        .src_pend (src_pend),
        .src_en   (src_en),
        .src_lvl  (src_lvl),
        .src_cfg  (src_cfg),
        .src_tgt  (src_tgt),
        .dom_ie   (dom_ie),
        .msg_word (msg_word),
        .rdata    (rsp_rdata)
    );

    ird_wrfwd #(.NSRC(NSRC), .IDXW(IDXW)) u_wrfwd (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_go     (wr_go),
        .region    (region),
        .index     (index),
        .wdata     (req_wdata),
        .pend_set  (pend_set),
        .pend_clr  (pend_clr),
        .en_set    (en_set),
        .en_clr    (en_clr),
        .cfg_we    (cfg_we),
        .tgt_we    (tgt_we),
        .arr_idx   (arr_idx),
        .arr_wdata (arr_wdata),
        .msg_fire  (msg_fire),
        .msg_word  (msg_word),
        .dom_ie    (dom_ie)
    );

    AST_RSP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid); // R2

    AST_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid); // R2

    AST_NAK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_rdata == '0 && pend_set == '0 && pend_clr == '0 &&
                     en_set == '0 && en_clr == '0 && !cfg_we && !tgt_we && !msg_fire)); // R1

    AST_NAK_KEEPS_IE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> $stable(dom_ie)); // R1

endmodule

// File: tb/intc_reg_decoder_tb.sv
`timescale 1ns/1ps
module intc_reg_decoder_tb;
    localparam int NS = 63;
    localparam int AW = 15;
    localparam int IW = 6;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic [AW-1:0]     req_addr = '0;
    logic [2:0]        req_size = 3'd4;
    logic [31:0]       req_wdata = '0;
    logic              rsp_valid, rsp_err;
    logic [31:0]       rsp_rdata;
    logic [NS:1]       src_pend = '0, src_en = '0, src_lvl = '0;
    logic [NS-1:0][31:0] src_cfg = '0, src_tgt = '0;
    logic [NS:1]       pend_set, pend_clr, en_set, en_clr;
    logic              cfg_we, tgt_we, msg_fire, dom_ie;
    logic [IW-1:0]     arr_idx;
    logic [31:0]       arr_wdata, msg_word;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    logic        m_ie = 1'b0;
    logic [31:0] m_msg = '0;

    logic        e_err, e_cfg, e_tgt, e_fire;
    logic [31:0] e_rd, e_wd;
    logic [IW-1:0] e_idx;
    logic [NS:1] e_ps, e_pc, e_es, e_ec;
    string       tg;

    always #4 clk = ~clk;

    intc_reg_decoder #(.NSRC(NS), .AW(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .src_pend(src_pend), .src_en(src_en), .src_lvl(src_lvl),
        .src_cfg(src_cfg), .src_tgt(src_tgt),
        .pend_set(pend_set), .pend_clr(pend_clr), .en_set(en_set), .en_clr(en_clr),
        .cfg_we(cfg_we), .tgt_we(tgt_we), .arr_idx(arr_idx), .arr_wdata(arr_wdata),
        .msg_fire(msg_fire), .msg_word(msg_word), .dom_ie(dom_ie)
    );

    task automatic chk(input string t, input string what, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", t, what, act, exp);
        end
    endtask

    function automatic logic [31:0] vword(input logic [NS:1] v, input int w);
        logic [31:0] r = '0;
        for (int i = 0; i < 32; i++) begin
            int s = w * 32 + i;
            if (s >= 1 && s <= NS) r[i] = v[s];
        end
        return r;
    endfunction

    function automatic logic [NS:1] vmask(input int w, input logic [31:0] d);
        logic [NS:1] r = '0;
        for (int s = 1; s <= NS; s++)
            if (s / 32 == w && d[s % 32]) r[s] = 1'b1;
        return r;
    endfunction

    function automatic logic [NS:1] nmask(input logic [31:0] v);
        logic [NS:1] r = '0;
        if (v >= 32'd1 && v <= 32'(NS)) r[v] = 1'b1;
        return r;
    endfunction

    function automatic logic [31:0] bswap(input logic [31:0] v);
        return {v[7:0], v[15:8], v[23:16], v[31:24]};
    endfunction

    task automatic predict(input logic wr, input int off, input logic [2:0] sz, input logic [31:0] wd);
        e_err = 1'b0; e_rd = '0; e_cfg = 1'b0; e_tgt = 1'b0; e_fire = 1'b0;
        e_ps = '0; e_pc = '0; e_es = '0; e_ec = '0;
        tg = "R1";
        if ((off % 4) != 0 || sz != 3'd4) begin
            e_err = 1'b1;
        end else if (off == 0) begin
            tg = "R3";
            if (wr) m_ie = wd[8];
            else    e_rd = 32'h8000_0004 | (32'(m_ie) << 8);
        end else if (off >= 4 && off < 4 + 4 * NS) begin
            tg = "R4";
            if (wr) begin e_cfg = 1'b1; e_idx = IW'((off - 4) / 4 + 1); e_wd = wd; end
            else e_rd = src_cfg[(off - 4) / 4];
        end else if (off >= 'h3004 && off < 'h3004 + 4 * NS) begin
            tg = "R5";
            if (wr) begin e_tgt = 1'b1; e_idx = IW'((off - 'h3004) / 4 + 1); e_wd = wd; end
            else e_rd = src_tgt[(off - 'h3004) / 4];
        end else if (off >= 'h1C00 && off < 'h1C08) begin
            tg = wr ? "R7" : "R6";
            if (wr) e_ps = vmask((off - 'h1C00) / 4, wd); else e_rd = vword(src_pend, (off - 'h1C00) / 4);
        end else if (off >= 'h1D00 && off < 'h1D08) begin
            tg = wr ? "R7" : "R6";
            if (wr) e_pc = vmask((off - 'h1D00) / 4, wd); else e_rd = vword(src_lvl, (off - 'h1D00) / 4);
        end else if (off >= 'h1E00 && off < 'h1E08) begin
            tg = wr ? "R7" : "R6";
            if (wr) e_es = vmask((off - 'h1E00) / 4, wd); else e_rd = vword(src_en, (off - 'h1E00) / 4);
        end else if (off >= 'h1F00 && off < 'h1F08) begin
            tg = wr ? "R7" : "R6";
            if (wr) e_ec = vmask((off - 'h1F00) / 4, wd);
        end else if (off == 'h1CDC || off == 'h2000) begin
            tg = "R8"; if (wr) e_ps = nmask(wd);
        end else if (off == 'h1DDC) begin
            tg = "R8"; if (wr) e_pc = nmask(wd);
        end else if (off == 'h1EDC) begin
            tg = "R8"; if (wr) e_es = nmask(wd);
        end else if (off == 'h1FDC) begin
            tg = "R8"; if (wr) e_ec = nmask(wd);
        end else if (off == 'h2004) begin
            tg = "R9"; if (wr) e_ps = nmask(bswap(wd));
        end else if (off == 'h3000) begin
            tg = "R10";
            if (wr) begin m_msg = wd & ~32'h0003_F000; e_fire = 1'b1; end
            else e_rd = m_msg;
        end else begin
            e_err = 1'b1;
        end
    endtask

    task automatic shuffle_state();
        src_pend = {$urandom, $urandom};
        src_en   = {$urandom, $urandom};
        src_lvl  = {$urandom, $urandom};
        for (int k = 0; k < NS; k++) begin
            src_cfg[k] = $urandom;
            src_tgt[k] = $urandom;
        end
    endtask

    task automatic access(input logic wr, input int off, input logic [2:0] sz, input logic [31:0] wd);
        shuffle_state();
        req_valid = 1'b1; req_write = wr; req_addr = AW'(off); req_size = sz; req_wdata = wd;
        predict(wr, off, sz, wd);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R2", "rsp_valid", 64'(rsp_valid), 64'd1);
        chk(tg, "rsp_err", 64'(rsp_err), 64'(e_err));
        chk(tg, "rsp_rdata", 64'(rsp_rdata), 64'(e_rd));
        chk(e_err ? "R1" : "R7", "pend_set", 64'(pend_set), 64'(e_ps));
        chk(e_err ? "R1" : "R7", "pend_clr", 64'(pend_clr), 64'(e_pc));
        chk(e_err ? "R1" : "R8", "en_set", 64'(en_set), 64'(e_es));
        chk(e_err ? "R1" : "R8", "en_clr", 64'(en_clr), 64'(e_ec));
        chk(e_err ? "R1" : "R4", "cfg_we", 64'(cfg_we), 64'(e_cfg));
        chk(e_err ? "R1" : "R5", "tgt_we", 64'(tgt_we), 64'(e_tgt));
        if (e_cfg || e_tgt) begin
            chk(tg, "arr_idx", 64'(arr_idx), 64'(e_idx));
            chk(tg, "arr_wdata", 64'(arr_wdata), 64'(e_wd));
        end
        chk(e_err ? "R1" : "R10", "msg_fire", 64'(msg_fire), 64'(e_fire));
        chk("R10", "msg_word", 64'(msg_word), 64'(m_msg));
        chk("R3", "dom_ie", 64'(dom_ie), 64'(m_ie));
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'd4242);
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R11 reset state
        chk("R11", "rsp_valid", 64'(rsp_valid), 64'd0);
        chk("R11", "masks", 64'(pend_set | pend_clr | en_set | en_clr), 64'd0);
        chk("R11", "strobes", 64'({cfg_we, tgt_we, msg_fire, dom_ie}), 64'd0);
        chk("R11", "msg_word", 64'(msg_word), 64'd0);
        rst_n = 1'b1;
        @(posedge clk); @(negedge clk);
        chk("R2", "idle rsp_valid", 64'(rsp_valid), 64'd0);

        // directed corners
        access(1'b0, 'h0000, 3'd4, 0);
        access(1'b1, 'h0000, 3'd4, 32'hFFFF_FFFF);
        access(1'b0, 'h0000, 3'd4, 0);
        access(1'b1, 'h0000, 3'd2, 32'h0000_0000);   // R1 size error keeps ie
        access(1'b1, 'h0000, 3'd4, 32'hFFFF_FEFF);
        access(1'b0, 'h0000, 3'd4, 0);
        access(1'b0, 4 + 4 * (NS - 1), 3'd4, 0);
        access(1'b0, 4 + 4 * NS, 3'd4, 0);           // one past config end
        access(1'b1, 4 + 4 * (NS - 1), 3'd4, 32'hA5A5_0001);
        access(1'b1, 'h3004, 3'd4, 32'h1234_5678);
        access(1'b1, 'h3004 + 4 * NS, 3'd4, 32'h1);
        access(1'b1, 'h1C00, 3'd4, 32'h0000_0001);   // source 0 bit only
        access(1'b1, 'h1C04, 3'd4, 32'h8000_0000);   // source 63
        access(1'b0, 'h1C08, 3'd4, 0);               // past vector end
        access(1'b0, 'h1F00, 3'd4, 0);
        access(1'b1, 'h1CDC, 3'd4, 32'd0);
        access(1'b1, 'h1DDC, 3'd4, 32'd64);
        access(1'b1, 'h1EDC, 3'd4, 32'd63);
        access(1'b1, 'h2004, 3'd4, 32'h3F00_0000);
        access(1'b1, 'h2004, 3'd4, 32'h0000_003F);
        access(1'b0, 'h2004, 3'd4, 0);
        access(1'b1, 'h3000, 3'd4, 32'hFFFF_FFFF);
        access(1'b0, 'h3000, 3'd4, 0);
        access(1'b0, 'h0802, 3'd4, 0);
        access(1'b1, 'h1CDE, 3'd4, 32'd5);

        // constrained random
        for (int n = 0; n < 600; n++) begin
            int kind, off;
            logic [2:0] sz;
            logic [31:0] wd;
            kind = $urandom_range(0, 14);
            wd = $urandom;
            case (kind)
                0: off = 0;
                1, 14: off = 4 + 4 * $urandom_range(0, NS);
                2: off = 'h3004 + 4 * $urandom_range(0, NS);
                3: off = 'h1C00 + 4 * $urandom_range(0, 2);
                4: off = 'h1D00 + 4 * $urandom_range(0, 2);
                5: off = 'h1E00 + 4 * $urandom_range(0, 2);
                6: off = 'h1F00 + 4 * $urandom_range(0, 2);
                7: begin off = 'h1CDC; wd = $urandom_range(0, 70); end
                8: begin off = 'h1DDC; wd = $urandom_range(0, 70); end
                9: begin off = 'h1EDC; wd = $urandom_range(0, 70); end
                10: begin off = 'h1FDC; wd = $urandom_range(0, 70); end
                11: begin off = 'h2000; wd = $urandom_range(0, 70); end
                12: begin off = 'h2004; wd = bswap($urandom_range(0, 70)); end
                default: off = 'h3000 + 4 * $urandom_range(0, 3) * $urandom_range(0, 1);
            endcase
            if (kind == 13 && $urandom_range(0, 1) == 1) off = int'($urandom_range(0, 32767)) & ~3;
            if ($urandom_range(0, 11) == 0) off = off + int'($urandom_range(1, 3));
            sz = 3'd4;
            if ($urandom_range(0, 11) == 0) sz = 3'($urandom_range(0, 3) * 2 + 1);
            access(1'($urandom_range(0, 1)), off, sz, wd);
        end

        @(negedge clk);
        chk("R2", "idle after burst", 64'(rsp_valid), 64'd0);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule